// File: doc/BRIEF.md
# Local Interrupt Controller Base and Mode Guard

This block owns the base/mode register of a local interrupt controller. A proposed write carries a new base address, a global enable flag and an extended-mode flag. The block works out whether the write is a legal step in the controller's one-way mode machine. The three modes are disabled, compact-ID mode (enable set, extended clear) and extended-ID mode (both set). A legal write is committed. An illegal write is discarded and flagged. Two side effects go with a committed write. Disabling the controller sends a request to clear the software-enable bit of the spurious-vector register. Entering extended mode loads a derived logical ID.

The block also screens register accesses by offset against the current mode. It denies the offsets that extended mode forbids and the self-IPI offset outside extended mode. Any access to an offset that has no register sets a sticky illegal-address error bit.

Top module: `lapic_mode_guard`

## Requirements
- R1: After reset, `base_reg` reads base field 0xFEE00 in bits 31:12, enable (bit 11) set, extended (bit 10) clear, bootstrap (bit 8) equal to `bsp_init`, and all other bits zero. `mode` reads 1. All pulse outputs, `esr_illegal_addr` and `x2_logical_id` are zero.
- R2: A base write with `wr_extended` set is rejected while `x2_capable` is low.
- R3: A base write with `wr_extended` set and `wr_enable` clear is rejected.
- R4: From disabled (`mode`=0), a write setting both enable and extended is rejected. A write setting enable only is accepted and gives `mode`=1.
- R5: From extended mode (`mode`=3), a write with enable set and extended clear is rejected. A write clearing both is accepted and gives `mode`=0.
- R6: An accepted write loads bits 31:12 from `wr_base`, bit 11 from `wr_enable` and bit 10 from `wr_extended`, and keeps bootstrap bit 8 unchanged. `mode` is 0 when enable is clear, 1 when only enable is set, and 3 when both are set.
- R7: A rejected write raises `base_reject` for exactly the one cycle after the write and leaves `base_reg`, `mode` and `x2_logical_id` unchanged.
- R8: An accepted write with enable clear raises `sw_enable_clr` for the one cycle after the write.
- R9: An accepted write with extended set loads `x2_logical_id` = {init_id[15:4], 4'b0000, one-hot of init_id[3:0] in bits 15:0}. This equals ((id & 0xFFFF0) << 16) | (1 << (id & 0xF)) truncated to 32 bits.
- R10: In extended mode, writes to offsets 0x02, 0x0D, 0x0E and 0x31 and reads of 0x0E are denied (`reg_access_deny` pulse) without setting the error bit. In the other modes the same accesses are accepted (`reg_access_ok` pulse).
- R11: A write to offset 0x3F is accepted only in extended mode and is otherwise denied without setting the error bit. A read of 0x3F is treated as unimplemented.
- R12: A read or write of an unimplemented offset is denied and sets `esr_illegal_addr`, which then stays set until reset. The implemented offsets are 0x02, 0x03, 0x08–0x0B, 0x0D–0x28, 0x30–0x39 and 0x3E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x2_capable | input | 1 | Extended mode is allowed |
| bsp_init | input | 1 | Bootstrap flag value loaded at reset |
| init_id | input | 16 | Initial controller ID (higher bits do not affect the logical ID) |
| base_wr | input | 1 | Propose a base/mode write this cycle |
| wr_base | input | 20 | Proposed base address field |
| wr_enable | input | 1 | Proposed global enable |
| wr_extended | input | 1 | Proposed extended-mode flag |
| reg_wr | input | 1 | Register write access this cycle |
| reg_rd | input | 1 | Register read access this cycle |
| reg_offset | input | 8 | Register offset (index) of the access |
| base_reg | output | 32 | Committed base/mode register image |
| mode | output | 2 | 0 disabled, 1 compact-ID, 3 extended |
| base_reject | output | 1 | Pulse: last base write was rejected |
| sw_enable_clr | output | 1 | Pulse: clear the spurious-vector software enable |
| x2_logical_id | output | 32 | Derived extended logical ID |
| reg_access_ok | output | 1 | Pulse: last register access allowed |
| reg_access_deny | output | 1 | Pulse: last register access refused |
| esr_illegal_addr | output | 1 | Sticky illegal-address error bit |

## Verification
The bench attacks the four illegal-transition rules one at a time. A guard that lets disabled go straight to extended, or extended drop back to compact mode, would show a committed `mode` change where the model expects a reject pulse. The bench writes bootstrap-independent data to catch a design that overwrites bootstrap from the data, and it checks the logical ID with IDs whose low nibble varies, which exposes a wrong shift or mask. The register screen is exercised on both sides of the mode boundary, so a design that sets the error bit for mode denials, or allows 0x3F in compact mode, fails.

// File: rtl/lmc_pkg.sv
// Package: shared mode encoding and register-image bit positions for the
// local controller base/mode guard. Assumes a 32-bit register image.
package lmc_pkg;
    typedef enum logic [1:0] {
        LMC_OFF   = 2'd0,
        LMC_XAPIC = 2'd1,
        LMC_X2    = 2'd3
    } lmc_mode_e;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned BOOT_BIT = 8;
    localparam int unsigned EXT_BIT  = 10;
    localparam int unsigned EN_BIT   = 11;
    localparam int unsigned BASE_LSB = 12;
    localparam int unsigned BASE_W   = REG_W - BASE_LSB;

    // Map the enable/extended pair onto a mode code.
    function automatic lmc_mode_e mode_of(input logic en, input logic ext);
        if (en && ext)
            return LMC_X2;
        else if (en)
            return LMC_XAPIC;
        else
            return LMC_OFF;
    endfunction
endpackage

// File: rtl/lmc_base_fsm.sv
// Module: base/mode register with legality check of proposed writes.
// Assumes at most one proposed write per cycle; outputs update on the
// edge that samples the write.
module lmc_base_fsm
    import lmc_pkg::*;
#(
    parameter int unsigned BW         = BASE_W,
    parameter logic [BW-1:0] RST_BASE = 20'hFEE00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x2_capable,
    input  logic          bsp_init,
    input  logic          wr,
    input  logic [BW-1:0] wr_base,
    input  logic          wr_en,
    input  logic          wr_ext,
    output logic [BW-1:0] base_q,
    output logic          en_q,
    output logic          ext_q,
    output logic          boot_q,
    output logic          reject_q,
    output logic          disable_q,
    output logic          x2_load
);
    logic illegal;
    logic accept;

    // Decide whether the proposed write breaks a mode rule.
    always_comb begin
        illegal = 1'b0;
        if (wr_ext && !x2_capable)                      illegal = 1'b1;
        if (wr_ext && !wr_en)                           illegal = 1'b1;
        if (!en_q && !ext_q && wr_en && wr_ext)         illegal = 1'b1;
        if (en_q && ext_q && wr_en && !wr_ext)          illegal = 1'b1;
    end

    assign accept  = wr && !illegal;
    assign x2_load = accept && wr_ext;

    // Commit accepted writes and raise the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= RST_BASE;
            en_q      <= 1'b1;
            ext_q     <= 1'b0;
            boot_q    <= bsp_init;
            reject_q  <= 1'b0;
            disable_q <= 1'b0;
        end else begin
            reject_q  <= wr && illegal;
            disable_q <= accept && !wr_en;
            if (accept) begin
                base_q <= wr_base;
                en_q   <= wr_en;
                ext_q  <= wr_ext;
            end
        end
    end

    lmc_mode_e mode_now;
    assign mode_now = mode_of(en_q, ext_q);

    assert_no_invalid_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_q && !en_q));
    assert_off_not_to_x2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == LMC_OFF) |=> (mode_now != LMC_X2));
    assert_x2_not_to_xapic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == LMC_X2) |=> (mode_now != LMC_XAPIC));
    assert_reject_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reject_q |-> (base_q == $past(base_q) && en_q == $past(en_q) && ext_q == $past(ext_q)));
    assert_disable_clears_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disable_q |-> !en_q);
    assert_boot_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(boot_q));
endmodule

// File: rtl/lmc_logid.sv
// Module: holds the derived extended logical ID; loads it from the initial
// ID whenever an accepted write enters or stays in extended mode.
// Assumes only ID bits 15:0 reach a 32-bit result.
module lmc_logid #(
    parameter int unsigned ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ID_W-1:0] init_id,
    output logic [31:0]     log_id_q
);
    logic [15:0] member_bit;

    // One-hot position of the controller inside its cluster.
    always_comb member_bit = 16'(1) << init_id[3:0];

    // Capture cluster number and member bit on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            log_id_q <= '0;
        else if (load)
            log_id_q <= {init_id[15:4], 4'b0000, member_bit};
    end

    assert_logid_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> $onehot(log_id_q[15:0]));
endmodule

// File: rtl/lmc_reg_gate.sv
// Module: screens register accesses by offset and current mode; raises
// one-cycle allow/deny pulses and a sticky illegal-address bit.
// Assumes a write takes precedence when read and write come together.
module lmc_reg_gate #(
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_x2,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFF_W-1:0] offset,
    output logic             ok_q,
    output logic             deny_q,
    output logic             illegal_q
);
    logic known;
    logic mode_block;

    // Which offsets hold a register at all.
    always_comb begin
        unique case (offset) inside
            8'h02, 8'h03, [8'h08:8'h0B], [8'h0D:8'h28],
            [8'h30:8'h39], 8'h3E:  known = 1'b1;
            default:               known = 1'b0;
        endcase
    end

    // Mode-dependent refusals of otherwise valid offsets.
    always_comb begin
        mode_block = 1'b0;
        if (wr) begin
            if (in_x2 && (offset == 8'h02 || offset == 8'h0D ||
                          offset == 8'h0E || offset == 8'h31))
                mode_block = 1'b1;
            if (!in_x2 && offset == 8'h3F)
                mode_block = 1'b1;
        end else if (in_x2 && offset == 8'h0E) begin
            mode_block = 1'b1;
        end
    end

    logic access, wr_self, unknown;
    assign access  = wr || rd;
    assign wr_self = wr && offset == 8'h3F;
    assign unknown = !known && !wr_self;

    // Register the outcome pulses and the sticky error bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q      <= 1'b0;
            deny_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            ok_q   <= access && !unknown && !mode_block;
            deny_q <= access && (unknown || mode_block);
            if (access && unknown)
                illegal_q <= 1'b1;
        end
    end

    assert_ok_deny_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_q && deny_q));
    assert_esr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> illegal_q);
    assert_self_ipi_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && offset == 8'h3F && !in_x2) |=> (deny_q && !ok_q));
endmodule

// File: rtl/lapic_mode_guard.sv
// Module: top of the base/mode guard. Joins the mode state machine, the
// logical-ID register and the register-access screen, and forms the
// 32-bit register image. Assumes synchronous active-low reset.
module lapic_mode_guard
    import lmc_pkg::*;
#(
    parameter int unsigned ID_W            = 16,
    parameter int unsigned OFF_W           = 8,
    parameter logic [BASE_W-1:0] RST_BASE  = 20'hFEE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x2_capable,
    input  logic              bsp_init,
    input  logic [ID_W-1:0]   init_id,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] wr_base,
    input  logic              wr_enable,
    input  logic              wr_extended,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [OFF_W-1:0]  reg_offset,
    output logic [REG_W-1:0]  base_reg,
    output logic [1:0]        mode,
    output logic              base_reject,
    output logic              sw_enable_clr,
    output logic [31:0]       x2_logical_id,
    output logic              reg_access_ok,
    output logic              reg_access_deny,
    output logic              esr_illegal_addr
);
    logic [BASE_W-1:0] base_q;
    logic en_q, ext_q, boot_q, x2_load;

    lmc_base_fsm #(.BW(BASE_W), .RST_BASE(RST_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .x2_capable(x2_capable), .bsp_init(bsp_init),
        .wr(base_wr), .wr_base(wr_base), .wr_en(wr_enable), .wr_ext(wr_extended),
        .base_q(base_q), .en_q(en_q), .ext_q(ext_q), .boot_q(boot_q),
        .reject_q(base_reject), .disable_q(sw_enable_clr), .x2_load(x2_load)
    );

    lmc_logid #(.ID_W(ID_W)) u_logid (
        .clk(clk), .rst_n(rst_n), .load(x2_load), .init_id(init_id),
        .log_id_q(x2_logical_id)
    );

    lmc_reg_gate #(.OFF_W(OFF_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .in_x2(en_q && ext_q), .wr(reg_wr), .rd(reg_rd),
        .offset(reg_offset), .ok_q(reg_access_ok), .deny_q(reg_access_deny),
        .illegal_q(esr_illegal_addr)
    );

    // Assemble the register image from its fields.
    always_comb begin
        base_reg                          = '0;
        base_reg[REG_W-1:BASE_LSB]        = base_q;
        base_reg[EN_BIT]                  = en_q;
        base_reg[EXT_BIT]                 = ext_q;
        base_reg[BOOT_BIT]                = boot_q;
    end

    assign mode = mode_of(en_q, ext_q);

    assert_mode_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd2);
endmodule

// File: tb/test_lapic_mode_guard.sv
`timescale 1ns/1ps
module test_lapic_mode_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x2_capable = 1'b0, bsp_init = 1'b1;
    logic [15:0] init_id = '0;
    logic base_wr = 1'b0, wr_enable = 1'b0, wr_extended = 1'b0;
    logic [19:0] wr_base = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_offset = '0;
    logic [31:0] base_reg, x2_logical_id;
    logic [1:0] mode;
    logic base_reject, sw_enable_clr, reg_access_ok, reg_access_deny, esr_illegal_addr;

    int n_run = 0, n_fail = 0;

    // model state
    logic [19:0] m_base;
    logic m_en, m_ext, m_boot, m_esr;
    logic [31:0] m_log;

    always #4 clk = ~clk;

    lapic_mode_guard i_lapic_mode_guard (
        .clk(clk), .rst_n(rst_n), .x2_capable(x2_capable), .bsp_init(bsp_init),
        .init_id(init_id), .base_wr(base_wr), .wr_base(wr_base), .wr_enable(wr_enable),
        .wr_extended(wr_extended), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_offset(reg_offset),
        .base_reg(base_reg), .mode(mode), .base_reject(base_reject),
        .sw_enable_clr(sw_enable_clr), .x2_logical_id(x2_logical_id),
        .reg_access_ok(reg_access_ok), .reg_access_deny(reg_access_deny),
        .esr_illegal_addr(esr_illegal_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] img();
        return {m_base, m_en, m_ext, 1'b0, m_boot, 8'h00};
    endfunction

    function automatic logic [1:0] m_mode();
        return m_en ? (m_ext ? 2'd3 : 2'd1) : 2'd0;
    endfunction

    function automatic logic [31:0] logid_of(input logic [15:0] id);
        logic [31:0] v;
        v = ({16'h0, id} & 32'h000F_FFF0) << 16;
        return v | (32'h1 << id[3:0]);
    endfunction

    function automatic logic is_bad(input logic en, input logic ext, input logic cap);
        return (ext && !cap) || (ext && !en) || (!m_en && !m_ext && en && ext)
            || (m_en && m_ext && en && !ext);
    endfunction

    function automatic logic known_off(input logic [7:0] o);
        return o == 8'h02 || o == 8'h03 || (o >= 8'h08 && o <= 8'h0B) ||
               (o >= 8'h0D && o <= 8'h28) || (o >= 8'h30 && o <= 8'h39) || o == 8'h3E;
    endfunction

    task automatic base_write(input string req, input logic [19:0] b, input logic en,
                              input logic ext, input logic cap, input logic [15:0] id);
        logic bad;
        @(negedge clk);
        base_wr = 1'b1; wr_base = b; wr_enable = en; wr_extended = ext;
        x2_capable = cap; init_id = id;
        bad = is_bad(en, ext, cap);
        @(posedge clk); #1;
        base_wr = 1'b0;
        check({req, " R7 reject pulse"}, {31'h0, base_reject}, {31'h0, bad});
        check({req, " R8 disable pulse"}, {31'h0, sw_enable_clr}, {31'h0, !bad && !en});
        if (!bad) begin
            m_base = b; m_en = en; m_ext = ext;
            if (ext) m_log = logid_of(id);
        end
        check({req, " R6 image"}, base_reg, img());
        check({req, " R6 mode"}, {30'h0, mode}, {30'h0, m_mode()});
        check({req, " R9 logical id"}, x2_logical_id, m_log);
    endtask

    task automatic reg_access(input string req, input logic w, input logic [7:0] o);
        logic x2, unk, blk;
        @(negedge clk);
        reg_wr = w; reg_rd = !w; reg_offset = o;
        x2 = m_en && m_ext;
        unk = !known_off(o) && !(w && o == 8'h3F);
        blk = w ? ((x2 && (o == 8'h02 || o == 8'h0D || o == 8'h0E || o == 8'h31)) ||
                   (!x2 && o == 8'h3F))
                : (x2 && o == 8'h0E);
        if (unk) m_esr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
        check({req, " ok"}, {31'h0, reg_access_ok}, {31'h0, !unk && !blk});
        check({req, " deny"}, {31'h0, reg_access_deny}, {31'h0, unk || blk});
        check({req, " R12 esr"}, {31'h0, esr_illegal_addr}, {31'h0, m_esr});
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_base = 20'hFEE00; m_en = 1'b1; m_ext = 1'b0; m_boot = 1'b1;
        m_esr = 1'b0; m_log = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 image", base_reg, img());
        check("R1 mode", {30'h0, mode}, 32'd1);
        check("R1 pulses", {28'h0, base_reject, sw_enable_clr, reg_access_ok, reg_access_deny}, 32'h0);
        check("R1 esr/logid", {31'h0, esr_illegal_addr} | x2_logical_id, 32'h0);

        base_write("R2 ext without capability", 20'h11111, 1, 1, 0, 16'h0005);
        @(posedge clk); #1;
        check("R7 reject lasts one cycle", {31'h0, base_reject}, 32'h0);
        base_write("R3 ext with enable clear", 20'h22222, 0, 1, 1, 16'h0005);
        base_write("R8 disable", 20'h12345, 0, 0, 1, 16'h0005);
        @(posedge clk); #1;
        check("R8 disable pulse one cycle", {31'h0, sw_enable_clr}, 32'h0);
        base_write("R4 off to x2", 20'h33333, 1, 1, 1, 16'h0005);
        base_write("R4 off to xapic", 20'h44444, 1, 0, 1, 16'h0005);
        reg_access("R11 self-ipi in xapic", 1, 8'h3F);
        reg_access("R10 id write in xapic", 1, 8'h02);
        reg_access("R10 dfr read in xapic", 0, 8'h0E);
        base_write("R9 xapic to x2", 20'h55555, 1, 1, 1, 16'hABC7);
        reg_access("R10 id write in x2", 1, 8'h02);
        reg_access("R10 ldr write in x2", 1, 8'h0D);
        reg_access("R10 icr-high write in x2", 1, 8'h31);
        reg_access("R10 dfr read in x2", 0, 8'h0E);
        reg_access("R11 self-ipi in x2", 1, 8'h3F);
        reg_access("R11 self-ipi read", 0, 8'h3F);
        reg_access("R12 unimplemented write", 1, 8'h40);
        reg_access("R12 sticky after legal access", 0, 8'h08);
        base_write("R5 x2 to xapic", 20'h66666, 1, 0, 1, 16'h0012);
        base_write("R9 x2 rewrite", 20'h77777, 1, 1, 1, 16'h0F3E);
        base_write("R5 x2 to off", 20'h88888, 0, 0, 1, 16'h0012);

        for (int i = 0; i < 600; i++) begin
            if ($urandom % 4 == 0)
                reg_access("R10 random access", 1'($urandom), 8'($urandom % 8'h48));
            else
                base_write("R6 random write", 20'($urandom), 1'($urandom), 1'($urandom),
                           ($urandom % 4) != 0, 16'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule